// File: doc/BRIEF.md
# Sub-dword operand select and merge

This stage sits around an execution unit's arithmetic. On the way in, it takes two 32-bit source words and picks from each a byte, a half-word or the whole word. The picked field is moved down so its lowest bit lands at bit 0. It is then zero-extended, or sign-extended when that source asks for it. On the way out, it takes the narrow result of the arithmetic and writes it into one field of a 32-bit destination. The destination bits outside that field are then filled according to a fill policy.

Three fill policies exist. Keep copies the outside bits from the old destination word, which is a separate input. Zero clears them. Sign copies the result's sign into every bit above the field and clears every bit below it. All outputs are registered and load together whenever `in_valid` is high. Any reserved selector or policy code is handled as a safe default, and the stage flags it.

Top module: `subfield_route`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs become zero after that edge: `op_a`, `op_b`, `dst_new`, `out_valid` and `sel_err`.
- R2: Selector codes are: 0 = bits 31:0, 1 = 7:0, 2 = 15:8, 3 = 23:16, 4 = 31:24, 5 = 15:0, 6 = 31:16. When its extend flag is 0, a source's chosen field appears right-aligned at bit 0 and zero-extended on `op_a`/`op_b`.
- R3: When a source's extend flag is 1 and its field is 8 or 16 bits, the bits above the field take the field's top bit. With code 0 the flag changes nothing.
- R4: The destination selector uses the same codes. `res_in` bits [w-1:0] are written into destination field bits [lsb+w-1:lsb]. With code 0, `dst_new` equals `res_in`.
- R5: Fill code 1 (zero) clears every destination bit outside the field.
- R6: Fill code 2 (sign) sets every bit above the field to `res_in[w-1]` and clears every bit below the field.
- R7: Fill code 0 (keep) copies every bit outside the field from `dst_old`.
- R8: Selector code 7 on any selector is handled as code 0. Fill code 3 is handled as code 0. Either case sets `sel_err` to 1 for that transfer, and `sel_err` is 0 otherwise.
- R9: `out_valid` is `in_valid` delayed by one clock. When `in_valid` is low, all data outputs and `sel_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Load this cycle's inputs |
| src_a | input | 32 | First source word |
| sel_a | input | 3 | Field selector for first source |
| ext_a | input | 1 | Sign-extend first source field |
| src_b | input | 32 | Second source word |
| sel_b | input | 3 | Field selector for second source |
| ext_b | input | 1 | Sign-extend second source field |
| res_in | input | 32 | Narrow result, right-aligned |
| dst_sel | input | 3 | Destination field selector |
| fill_pol | input | 2 | Fill policy: 0 keep, 1 zero, 2 sign |
| dst_old | input | 32 | Previous destination value |
| op_a | output | 32 | Extracted first operand |
| op_b | output | 32 | Extracted second operand |
| dst_new | output | 32 | Merged destination word |
| out_valid | output | 1 | Outputs updated by last clock |
| sel_err | output | 1 | Reserved code seen in last transfer |

## Verification
Every result (`op_a`, `op_b`, `dst_new`, `sel_err`) is due on the first rising edge after the inputs are presented with `in_valid` high, since there is a single register stage. The bench changes inputs on falling edges and compares on the next falling edge, half a period after the capturing edge. The bench sweeps every selector, extend flag and fill code against several data patterns with sign bits set and clear. It also runs a hold phase with `in_valid` low, then samples one cycle later and expects the previous outputs unchanged.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    // Field selector codes shared by sources and destination
    typedef enum logic [2:0] {
        SEL_FULL = 3'd0,
        SEL_B0   = 3'd1,
        SEL_B1   = 3'd2,
        SEL_B2   = 3'd3,
        SEL_B3   = 3'd4,
        SEL_H0   = 3'd5,
        SEL_H1   = 3'd6,
        SEL_RSV  = 3'd7
    } fsel_e;

    // Fill policy for destination bits outside the field
    typedef enum logic [1:0] {
        FILL_KEEP = 2'd0,
        FILL_ZERO = 2'd1,
        FILL_SIGN = 2'd2,
        FILL_RSV  = 2'd3
    } fill_e;
endpackage

// File: rtl/field_decode.sv
// field_decode: turns a selector code into field position, width and masks.
// Assumes DW is a multiple of 4; byte = DW/4, half = DW/2.
// Reserved code maps to the full word and raises bad.
module field_decode #(
    parameter int DW = 32
) (
    input  logic [2:0]             sel,
    output logic [$clog2(DW)-1:0]  lsb,
    output logic [$clog2(DW):0]    wid,
    output logic [DW-1:0]          low_mask,
    output logic [DW-1:0]          fld_mask,
    output logic                   bad
);
    import sdw_pkg::*;
    localparam int LW = $clog2(DW);
    localparam int BW = DW / 4;
    localparam int HW = DW / 2;

    // Decode position and width of the selected field
    always_comb begin
        bad = 1'b0;
        lsb = '0;
        wid = (LW+1)'(DW);
        case (fsel_e'(sel))
            SEL_B0:  begin lsb = '0;             wid = (LW+1)'(BW); end
            SEL_B1:  begin lsb = LW'(BW);        wid = (LW+1)'(BW); end
            SEL_B2:  begin lsb = LW'(2*BW);      wid = (LW+1)'(BW); end
            SEL_B3:  begin lsb = LW'(3*BW);      wid = (LW+1)'(BW); end
            SEL_H0:  begin lsb = '0;             wid = (LW+1)'(HW); end
            SEL_H1:  begin lsb = LW'(HW);        wid = (LW+1)'(HW); end
            SEL_RSV: bad = 1'b1;
            default: ;
        endcase
    end

    // Build right-aligned and in-place masks of the field
    always_comb begin
        if (wid >= (LW+1)'(DW)) low_mask = '1;
        else                    low_mask = (DW'(1) << wid) - DW'(1);
        fld_mask = low_mask << lsb;
    end
endmodule

// File: rtl/operand_extract.sv
// operand_extract: picks a field of a source word, aligns it to bit 0
// and zero- or sign-extends it. Sign extension of a full word is a no-op.
module operand_extract #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] src,
    input  logic [2:0]    sel,
    input  logic          ext,
    output logic [DW-1:0] op,
    output logic          bad
);
    localparam int LW = $clog2(DW);

    logic [LW-1:0] lsb;
    logic [LW:0]   wid;
    logic [DW-1:0] low_mask;
    logic [DW-1:0] fld_mask;
    logic [DW-1:0] shifted;
    logic [LW-1:0] top_idx;
    logic          sign;

    field_decode #(.DW(DW)) u_dec (
        .sel(sel), .lsb(lsb), .wid(wid),
        .low_mask(low_mask), .fld_mask(fld_mask), .bad(bad)
    );

    // Align the field, then extend it to the full width
    always_comb begin
        shifted = src >> lsb;
        top_idx = LW'(wid - 1'b1);
        sign    = shifted[top_idx];
        op      = shifted & low_mask;
        if (ext && sign) op = op | ~low_mask;
    end

    // R3: a full-word selection passes the source through unchanged
    always_comb begin
        if (wid == (LW+1)'(DW))
            a_r3_full_passthru: assert (op == src);
    end
endmodule

// File: rtl/dest_merge.sv
// dest_merge: places a right-aligned result into a destination field
// and fills the remaining bits by policy (keep old, zero, or sign above /
// zero below). Reserved policy behaves as keep and raises bad.
module dest_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] res,
    input  logic [DW-1:0] old,
    input  logic [2:0]    sel,
    input  logic [1:0]    pol,
    output logic [DW-1:0] dnew,
    output logic [DW-1:0] fld_mask,
    output logic          bad
);
    import sdw_pkg::*;
    localparam int LW = $clog2(DW);

    logic [LW-1:0] lsb;
    logic [LW:0]   wid;
    logic [DW-1:0] low_mask;
    logic [DW-1:0] below;
    logic [DW-1:0] above;
    logic [DW-1:0] placed;
    logic [LW-1:0] top_idx;
    logic          sign;
    logic          sel_bad;

    field_decode #(.DW(DW)) u_dec (
        .sel(sel), .lsb(lsb), .wid(wid),
        .low_mask(low_mask), .fld_mask(fld_mask), .bad(sel_bad)
    );

    // Position the result and derive regions outside the field
    always_comb begin
        placed  = (res << lsb) & fld_mask;
        top_idx = LW'(wid - 1'b1);
        sign    = res[top_idx];
        below   = (DW'(1) << lsb) - DW'(1);
        above   = ~(fld_mask | below);
    end

    // Apply the fill policy to bits outside the field
    always_comb begin
        bad = sel_bad;
        case (fill_e'(pol))
            FILL_ZERO: dnew = placed;
            FILL_SIGN: dnew = sign ? (placed | above) : placed;
            FILL_RSV:  begin dnew = placed | (old & ~fld_mask); bad = 1'b1; end
            default:   dnew = placed | (old & ~fld_mask);
        endcase
    end

    // R6: sign fill leaves nothing set below the field
    always_comb begin
        if (fill_e'(pol) == FILL_SIGN)
            a_r6_below_clear: assert ((dnew & below) == '0);
    end
endmodule

// File: rtl/subfield_route.sv
// subfield_route: one registered stage that extracts two source operands
// and merges a result into a destination field. All outputs load together
// when in_valid is high and hold otherwise. Synchronous active-low reset.
module subfield_route #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] src_a,
    input  logic [2:0]    sel_a,
    input  logic          ext_a,
    input  logic [DW-1:0] src_b,
    input  logic [2:0]    sel_b,
    input  logic          ext_b,
    input  logic [DW-1:0] res_in,
    input  logic [2:0]    dst_sel,
    input  logic [1:0]    fill_pol,
    input  logic [DW-1:0] dst_old,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b,
    output logic [DW-1:0] dst_new,
    output logic          out_valid,
    output logic          sel_err
);
    import sdw_pkg::*;
    localparam int NSRC = 2;

    logic [DW-1:0] src_v [NSRC];
    logic [2:0]    sel_v [NSRC];
    logic          ext_v [NSRC];
    logic [DW-1:0] op_v  [NSRC];
    logic          bad_v [NSRC];
    logic [DW-1:0] merged;
    logic [DW-1:0] dmask;
    logic          dbad;
    logic          any_bad;

    // Gather the source ports into arrays for the extract lanes
    always_comb begin
        src_v[0] = src_a; sel_v[0] = sel_a; ext_v[0] = ext_a;
        src_v[1] = src_b; sel_v[1] = sel_b; ext_v[1] = ext_b;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        operand_extract #(.DW(DW)) u_ext (
            .src(src_v[g]), .sel(sel_v[g]), .ext(ext_v[g]),
            .op(op_v[g]), .bad(bad_v[g])
        );
    end

    dest_merge #(.DW(DW)) u_merge (
        .res(res_in), .old(dst_old), .sel(dst_sel), .pol(fill_pol),
        .dnew(merged), .fld_mask(dmask), .bad(dbad)
    );

    // Combine error indications of all selectors and the policy
    always_comb begin
        any_bad = dbad;
        for (int i = 0; i < NSRC; i++) any_bad = any_bad | bad_v[i];
    end

    // Output register stage with load enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a      <= '0;
            op_b      <= '0;
            dst_new   <= '0;
            out_valid <= 1'b0;
            sel_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                op_a    <= op_v[0];
                op_b    <= op_v[1];
                dst_new <= merged;
                sel_err <= any_bad;
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (out_valid == 1'b0 && sel_err == 1'b0 && dst_new == '0));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst_new) && $stable(op_a) && $stable(op_b)));

    a_r8_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sel_a == 3'd7 || sel_b == 3'd7 || dst_sel == 3'd7 || fill_pol == 2'd3))
        |=> sel_err);

    a_r4_full_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_sel == 3'd0) |=> dst_new == $past(res_in));

    a_r5_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill_pol == 2'd1) |=> (dst_new & ~$past(dmask)) == '0);

    a_r7_keep_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill_pol == 2'd0)
        |=> (dst_new & ~$past(dmask)) == ($past(dst_old) & ~$past(dmask)));
endmodule

// File: tb/test_subfield_route.sv
module test_subfield_route;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, res_in = '0, dst_old = '0;
    logic [2:0]  sel_a = '0, sel_b = '0, dst_sel = '0;
    logic        ext_a = 1'b0, ext_b = 1'b0;
    logic [1:0]  fill_pol = '0;
    logic [31:0] op_a, op_b, dst_new;
    logic        out_valid, sel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    subfield_route i_subfield_route (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .sel_a(sel_a), .ext_a(ext_a),
        .src_b(src_b), .sel_b(sel_b), .ext_b(ext_b),
        .res_in(res_in), .dst_sel(dst_sel), .fill_pol(fill_pol),
        .dst_old(dst_old), .op_a(op_a), .op_b(op_b), .dst_new(dst_new),
        .out_valid(out_valid), .sel_err(sel_err)
    );

    function automatic int f_lsb(input int s);
        if (s >= 1 && s <= 4) return (s - 1) * 8;
        if (s == 5 || s == 6) return (s - 5) * 16;
        return 0;
    endfunction

    function automatic int f_wid(input int s);
        if (s >= 1 && s <= 4) return 8;
        if (s == 5 || s == 6) return 16;
        return 32;
    endfunction

    function automatic logic [31:0] exp_op(input logic [31:0] v, input int s, input bit e);
        longint unsigned span = longint'(1) << f_wid(s);
        longint unsigned fld  = (longint'(v) >> f_lsb(s)) % span;
        if (e && f_wid(s) < 32 && fld >= span / 2) fld = fld + 64'hFFFF_FFFF_0000_0000 - span + 64'h1_0000_0000;
        return fld[31:0];
    endfunction

    function automatic logic [31:0] exp_dst(input logic [31:0] r, input logic [31:0] o,
                                            input int s, input int p);
        logic [31:0] x;
        int lo = f_lsb(s);
        int w  = f_wid(s);
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i < lo + w)   x[i] = r[i - lo];
            else if (p == 1)             x[i] = 1'b0;
            else if (p == 2)             x[i] = (i >= lo + w) ? r[w - 1] : 1'b0;
            else                         x[i] = o[i];
        end
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    localparam logic [31:0] PAT [4] = '{32'h8091_A2F3, 32'h7F00_7F80, 32'hFFFF_FFFF, 32'h1234_5678};

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ha, hb, hd;
        logic        he;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 op_a", op_a, 32'h0);
        chk("R1 dst_new", dst_new, 32'h0);
        chk("R1 flags", {30'h0, out_valid, sel_err}, 32'h0);
        rst_n = 1'b1;

        // R2 R3 R8: source extraction sweep
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 2; e++) begin
                for (int p = 0; p < 4; p++) begin
                    src_a = PAT[p]; src_b = ~PAT[(p + 1) % 4];
                    sel_a = 3'(s); sel_b = 3'(7 - s);
                    ext_a = 1'(e); ext_b = 1'(1 - e);
                    dst_sel = 3'd0; fill_pol = 2'd0; res_in = PAT[p]; dst_old = '0;
                    in_valid = 1'b1;
                    @(negedge clk);
                    chk(e ? "R3 op_a" : "R2 op_a", op_a, exp_op(src_a, s, 1'(e)));
                    chk(e ? "R2 op_b" : "R3 op_b", op_b, exp_op(src_b, 7 - s, 1'(1 - e)));
                    chk("R8 src err", {31'h0, sel_err}, {31'h0, (s == 0 || s == 7)});
                    chk("R9 out_valid", {31'h0, out_valid}, 32'h1);
                end
            end
        end

        // R4 R5 R6 R7 R8: destination merge sweep
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 4; k++) begin
                    sel_a = 3'd0; sel_b = 3'd0; ext_a = 1'b0; ext_b = 1'b0;
                    src_a = PAT[k]; src_b = PAT[k];
                    res_in = PAT[k]; dst_old = ~PAT[(k + 2) % 4];
                    dst_sel = 3'(s); fill_pol = 2'(p);
                    in_valid = 1'b1;
                    @(negedge clk);
                    case (p)
                        1:       chk("R5 zero fill", dst_new, exp_dst(res_in, dst_old, s, p));
                        2:       chk("R6 sign fill", dst_new, exp_dst(res_in, dst_old, s, p));
                        0:       chk("R7 keep fill", dst_new, exp_dst(res_in, dst_old, s, p));
                        default: chk("R8 rsv policy", dst_new, exp_dst(res_in, dst_old, s, p));
                    endcase
                    if (s == 0) chk("R4 full dest", dst_new, res_in);
                    chk("R8 dst err", {31'h0, sel_err}, {31'h0, (s == 7 || p == 3)});
                end
            end
        end

        // R9: idle cycle holds outputs
        ha = op_a; hb = op_b; hd = dst_new; he = sel_err;
        in_valid = 1'b0;
        src_a = 32'hDEAD_BEEF; src_b = 32'h0BAD_F00D; sel_a = 3'd7; res_in = 32'h5555_AAAA;
        fill_pol = 2'd1; dst_sel = 3'd2;
        @(negedge clk);
        chk("R9 valid low", {31'h0, out_valid}, 32'h0);
        chk("R9 hold op_a", op_a, ha);
        chk("R9 hold op_b", op_b, hb);
        chk("R9 hold dst", dst_new, hd);
        chk("R9 hold err", {31'h0, sel_err}, {31'h0, he});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule